// File: doc/BRIEF.md
# Fixed-Priority Vectored Interrupt Controller

This block gathers seventeen interrupt request slots, latches each event into a request flag and chooses, by a fixed hardware order, the one source that the processor should serve next. Slot 0 (highest priority) is the reset request and slot 16 (lowest) is the software break; both bypass all masking. The remaining slots are maskable: each needs its own enable bit set and the global disable flag clear. Slot 15 is reserved and never requests.

Most slots take single-cycle event pulses from timers, serial ports and the converter. Five slots are instead fed from pins inside the block. Four edge pins (slots 3, 4, 6, 7) each have a polarity bit choosing rising or falling edges. A key-wake slot (5) fires when the AND of an 8-bit port's levels falls. All pins pass through a two-flop synchronizer and a registered previous-value compare.

On an acknowledge the controller registers the winning slot index and its vector addresses, clears that flag and sets the global disable flag. The vector for slot i has its low byte at 0xFFFC − 2·i and its high byte one address above.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After synchronous reset, `irq` is 0, `gdis` is 1, `src_idx` is 0, `vec_lo` is 0xFFFC and `vec_hi` is 0xFFFD, and no flag is pending.
- R2: On `ack`, among accepted pending slots the lowest slot index wins and appears on `src_idx` the cycle after the acknowledge edge.
- R3: `vec_lo` always equals 0xFFFC − 2·`src_idx` and `vec_hi` equals `vec_lo` + 1.
- R4: A slot other than 0 and 16 is accepted only when its `en_mask` bit is 1 and `gdis` is 0; slots 0 and 16 are accepted whatever the enables and `gdis`.
- R5: Edge pin p (`pin_in[0..3]` → slots 3, 4, 6, 7) requests on a rising edge when `pin_rise[p]` is 1 and on a falling edge when it is 0; the other edge is ignored.
- R6: Slot 5 requests when the AND of all `key_port` bits goes from 1 to 0.
- R7: An `ack` clears the winning flag and sets `gdis` (set beats `gdis_clr`); `src_idx`, `vec_lo` and `vec_hi` do not change without an `ack` that finds a pending source.
- R8: An event arriving in the same cycle as a `sw_clr` of its own slot leaves the flag set.
- R9: `evt_in` bits 3, 4, 5, 6, 7 and 15 are ignored; slot 15 never requests.
- R10: `irq` is 1 exactly one cycle after a cycle in which some accepted request is pending.
- R11: A `sw_clr` bit clears the matching pending flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_in | input | 17 | Event pulses, one per slot |
| pin_in | input | 4 | Edge pins for slots 3, 4, 6, 7 |
| pin_rise | input | 4 | Per-pin polarity: 1 rising, 0 falling |
| key_port | input | 8 | Key-wake port levels |
| en_mask | input | 17 | Per-slot enable bits |
| sw_clr | input | 17 | Per-slot flag clear |
| gdis_set | input | 1 | Set the global disable flag |
| gdis_clr | input | 1 | Clear the global disable flag |
| ack | input | 1 | Acknowledge the current winner |
| irq | output | 1 | Accepted request pending |
| gdis | output | 1 | Global disable flag |
| src_idx | output | 5 | Acknowledged slot index |
| vec_lo | output | 16 | Address of the vector's low byte |
| vec_hi | output | 16 | Address of the vector's high byte |

## Verification
The bench builds the block with its defaults: seventeen slots, an 8-bit key port, two synchronizer stages and a top vector of 0xFFFC. With these values every slot, including both extremes 0xFFFC and 0xFFDC, and the reserved gap can be reached, and random mixes of simultaneous pulses with random enables exercise the priority order. The pin latency through the two stages plus the edge register stays short enough for directed edge and key-wake cases.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int SLOT_RST  = 0;
  localparam int SLOT_INT0 = 3;
  localparam int SLOT_INT1 = 4;
  localparam int SLOT_KEY  = 5;
  localparam int SLOT_CNT0 = 6;
  localparam int SLOT_CNT1 = 7;
  localparam int SLOT_RSV  = 15;
  localparam int SLOT_BRK  = 16;
  localparam int PIN_N     = 4;

  function automatic logic [15:0] vec_of(input logic [15:0] top, input int unsigned idx);
    return top - 16'(2 * idx);
  endfunction

  function automatic bit is_pin_slot(input int i);
    return (i == SLOT_INT0) || (i == SLOT_INT1) || (i == SLOT_KEY) ||
           (i == SLOT_CNT0) || (i == SLOT_CNT1);
  endfunction
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int W      = 12,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) chain_q[s] <= '0;
    end else begin
      chain_q[0] <= d;
      for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
    end
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/irq_edge.sv
module irq_edge #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= d;
  end

  assign rise = d & ~prev_q;
  assign fall = ~d & prev_q;
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int N     = 17,
  parameter int IDX_W = 5
) (
  input  logic [N-1:0]     req,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        any = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl #(
  parameter int          NUM_SRC     = 17,
  parameter int          IDX_W       = $clog2(NUM_SRC),
  parameter int          KEY_W       = 8,
  parameter int          SYNC_STAGES = 2,
  parameter logic [15:0] VEC_TOP     = 16'hFFFC
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] evt_in,
  input  logic [3:0]         pin_in,
  input  logic [3:0]         pin_rise,
  input  logic [KEY_W-1:0]   key_port,
  input  logic [NUM_SRC-1:0] en_mask,
  input  logic [NUM_SRC-1:0] sw_clr,
  input  logic               gdis_set,
  input  logic               gdis_clr,
  input  logic               ack,
  output logic               irq,
  output logic               gdis,
  output logic [IDX_W-1:0]   src_idx,
  output logic [15:0]        vec_lo,
  output logic [15:0]        vec_hi
);
  import irq_pkg::*;

  localparam int SYNC_W = PIN_N + KEY_W;
  localparam int EDGE_W = PIN_N + 1;

  logic [SYNC_W-1:0]  sync_q;
  logic [EDGE_W-1:0]  lvl, rise_w, fall_w;
  logic [1:0]         warm_q;
  logic               armed;
  logic [PIN_N-1:0]   pin_evt;
  logic               key_evt;
  logic [NUM_SRC-1:0] set_v, clr_v, flag_q, nmi_v, pend;
  logic               pend_any, gdis_q, irq_q;
  logic [IDX_W-1:0]   win_idx, idx_q;
  logic [15:0]        vlo_q, vhi_q;

  irq_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d({key_port, pin_in}), .q(sync_q)
  );

  assign lvl = {&sync_q[SYNC_W-1:PIN_N], sync_q[PIN_N-1:0]};

  irq_edge #(.W(EDGE_W)) u_edge (
    .clk(clk), .rst(rst), .d(lvl), .rise(rise_w), .fall(fall_w)
  );

  // edges are masked until the sync chain and compare register are filled
  always_ff @(posedge clk) begin
    if (rst)         warm_q <= '0;
    else if (!armed) warm_q <= warm_q + 2'd1;
  end
  assign armed = (warm_q == 2'd3);

  genvar gp;
  generate
    for (gp = 0; gp < PIN_N; gp++) begin : g_pin
      assign pin_evt[gp] = armed & (pin_rise[gp] ? rise_w[gp] : fall_w[gp]);
    end
  endgenerate
  assign key_evt = armed & fall_w[PIN_N];

  always_comb begin
    set_v = '0;
    nmi_v = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (!is_pin_slot(i) && (i != SLOT_RSV)) set_v[i] = evt_in[i];
    end
    set_v[SLOT_INT0] = pin_evt[0];
    set_v[SLOT_INT1] = pin_evt[1];
    set_v[SLOT_CNT0] = pin_evt[2];
    set_v[SLOT_CNT1] = pin_evt[3];
    set_v[SLOT_KEY]  = key_evt;
    nmi_v[SLOT_RST]  = 1'b1;
    nmi_v[SLOT_BRK]  = 1'b1;
  end

  assign pend = flag_q & (nmi_v | (en_mask & {NUM_SRC{~gdis_q}}));

  irq_pick #(.N(NUM_SRC), .IDX_W(IDX_W)) u_pick (
    .req(pend), .any(pend_any), .idx(win_idx)
  );

  always_comb begin
    clr_v = sw_clr;
    if (ack && pend_any) clr_v[win_idx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= '0;
      gdis_q <= 1'b1;
      irq_q  <= 1'b0;
      idx_q  <= '0;
      vlo_q  <= VEC_TOP;
      vhi_q  <= VEC_TOP + 16'd1;
    end else begin
      flag_q <= (flag_q & ~clr_v) | set_v;
      irq_q  <= pend_any;
      if (gdis_set || ack) gdis_q <= 1'b1;
      else if (gdis_clr)   gdis_q <= 1'b0;
      if (ack && pend_any) begin
        idx_q <= win_idx;
        vlo_q <= vec_of(VEC_TOP, 32'(win_idx));
        vhi_q <= vec_of(VEC_TOP, 32'(win_idx)) + 16'd1;
      end
    end
  end

  assign irq     = irq_q;
  assign gdis    = gdis_q;
  assign src_idx = idx_q;
  assign vec_lo  = vlo_q;
  assign vec_hi  = vhi_q;
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk #(
  parameter int          NUM_SRC = 17,
  parameter int          IDX_W   = 5,
  parameter logic [15:0] VEC_TOP = 16'hFFFC
) (
  input logic               clk,
  input logic               rst,
  input logic               ack,
  input logic               irq,
  input logic               gdis,
  input logic [IDX_W-1:0]   src_idx,
  input logic [15:0]        vec_lo,
  input logic [15:0]        vec_hi,
  input logic [NUM_SRC-1:0] flags
);
  AST_VEC_MAP: assert property (@(posedge clk) disable iff (rst)
    (vec_lo == VEC_TOP - 16'({src_idx, 1'b0})) && (vec_hi == vec_lo + 16'd1)); // R3

  AST_ACK_SETS_DIS: assert property (@(posedge clk) disable iff (rst)
    ack |=> gdis); // R7

  AST_VEC_HOLD: assert property (@(posedge clk) disable iff (rst)
    !ack |=> ($stable(src_idx) && $stable(vec_lo) && $stable(vec_hi))); // R7

  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (rst)
    (gdis && !flags[0] && !flags[NUM_SRC-1]) |=> !irq); // R4

  AST_NO_RESERVED: assert property (@(posedge clk) disable iff (rst)
    !flags[15]); // R9
endmodule

bind vec_irq_ctrl irq_ctrl_chk #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W), .VEC_TOP(VEC_TOP)) u_chk (
  .clk(clk), .rst(rst), .ack(ack), .irq(irq), .gdis(gdis), .src_idx(src_idx),
  .vec_lo(vec_lo), .vec_hi(vec_hi), .flags(flag_q)
);

// File: tb/vec_irq_ctrl_bench.sv
module vec_irq_ctrl_bench;
  localparam int N = 17;
  localparam logic [N-1:0] PULSE_SLOTS = 17'h17F07; // slots 0-2, 8-14, 16
  localparam logic [N-1:0] NMI_SLOTS   = 17'h10001;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0] evt_in = '0, en_mask = '0, sw_clr = '0;
  logic [3:0] pin_in = 4'b0100, pin_rise = 4'b1011;
  logic [7:0] key_port = 8'hFF;
  logic gdis_set = 1'b0, gdis_clr = 1'b0, ack = 1'b0;
  logic irq, gdis;
  logic [4:0] src_idx;
  logic [15:0] vec_lo, vec_hi;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  vec_irq_ctrl u_vec_irq_ctrl (
    .clk(clk), .rst(rst), .evt_in(evt_in), .pin_in(pin_in), .pin_rise(pin_rise),
    .key_port(key_port), .en_mask(en_mask), .sw_clr(sw_clr), .gdis_set(gdis_set),
    .gdis_clr(gdis_clr), .ack(ack), .irq(irq), .gdis(gdis), .src_idx(src_idx),
    .vec_lo(vec_lo), .vec_hi(vec_hi)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_vec(input int idx);
    return 16'hFFFC - 16'(2 * idx);
  endfunction

  function automatic int lowest(input logic [N-1:0] m);
    for (int i = N - 1; i >= 0; i--) if (m[i]) lowest = i;
  endfunction

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse(input logic [N-1:0] m);
    evt_in = m; tick(); evt_in = '0; tick();
  endtask

  task automatic do_ack();
    ack = 1'b1; tick(); ack = 1'b0;
  endtask

  task automatic clean();
    sw_clr = '1; gdis_clr = 1'b1; tick();
    sw_clr = '0; gdis_clr = 1'b0; tick(2);
  endtask

  task automatic ack_expect(input string req, input int idx);
    do_ack();
    check(req, src_idx, idx);
    check("R3 lo", vec_lo, exp_vec(idx));
    check("R3 hi", vec_hi, exp_vec(idx) + 16'd1);
  endtask

  initial begin
    void'($urandom(32'd7321));
    tick(3); rst = 1'b0; tick();
    // R1 reset state
    check("R1 irq", irq, 0);
    check("R1 gdis", gdis, 1);
    check("R1 idx", src_idx, 0);
    check("R1 lo", vec_lo, 16'hFFFC);
    check("R1 hi", vec_hi, 16'hFFFD);
    tick(5);

    // R2 R3 simultaneous requests
    en_mask = '1; clean();
    pulse(17'h01200); // slots 9 and 12
    check("R10 irq up", irq, 1);
    ack_expect("R2 first", 9);
    tick(); check("R7 gdis set", gdis, 1);
    check("R4 masked after ack", irq, 0);
    gdis_clr = 1'b1; tick(); gdis_clr = 1'b0; tick();
    check("R10 irq resumes", irq, 1);
    ack_expect("R2 second", 12);
    tick(); check("R11 ack cleared all", irq, 0);

    // R4 global disable and enables
    clean(); gdis_set = 1'b1; tick(); gdis_set = 1'b0;
    pulse(17'h00400);
    check("R4 gdis blocks", irq, 0);
    gdis_clr = 1'b1; tick(); gdis_clr = 1'b0; tick();
    check("R4 release", irq, 1);
    clean(); en_mask = '0; gdis_set = 1'b1; tick(); gdis_set = 1'b0;
    pulse(17'h10000);
    check("R4 break nmi", irq, 1);
    ack_expect("R4 break idx", 16);
    pulse(17'h00001);
    check("R4 reset nmi", irq, 1);
    ack_expect("R4 reset idx", 0);

    // R7 hold without ack
    en_mask = '1; clean(); pulse(17'h00002); tick(3);
    check("R7 hold idx", src_idx, 0);
    check("R7 hold lo", vec_lo, 16'hFFFC);

    // R5 edge pins
    clean(); pin_in[0] = 1'b1; tick(4);
    check("R5 rise int0", irq, 1);
    ack_expect("R5 int0 idx", 3);
    clean(); pin_in[0] = 1'b0; tick(6);
    check("R5 fall ignored", irq, 0);
    pin_in[2] = 1'b0; tick(4);
    check("R5 fall cnt0", irq, 1);
    ack_expect("R5 cnt0 idx", 6);

    // R6 key wake
    clean(); key_port = 8'hF7; tick(4);
    check("R6 key fall", irq, 1);
    ack_expect("R6 key idx", 5);
    clean(); key_port = 8'hFF; tick(6);
    check("R6 rise ignored", irq, 0);

    // R8 set beats clear
    clean(); evt_in = 17'h02000; sw_clr = 17'h02000; tick();
    evt_in = '0; sw_clr = '0; tick();
    check("R8 set wins", irq, 1);
    // R11 software clear
    sw_clr = 17'h02000; tick(); sw_clr = '0; tick();
    check("R11 sw clear", irq, 0);

    // R9 ignored evt bits
    clean(); pulse(17'h080F8); tick();
    check("R9 ignored", irq, 0);

    // random mixes
    for (int it = 0; it < 60; it++) begin
      logic [N-1:0] m, acc;
      en_mask = N'($urandom);
      clean();
      m = N'($urandom) & PULSE_SLOTS;
      acc = m & (en_mask | NMI_SLOTS);
      pulse(m);
      check("R10 rand irq", irq, {31'd0, |acc});
      if (|acc) begin
        ack_expect("R2 rand", lowest(acc));
        check("R7 rand gdis", gdis, 1);
      end
    end
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 20000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    #1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule